// File: doc/BRIEF.md
# Frequency select watchdog controller

This block chooses the 5-bit frequency-table code that steers a clock synthesizer and guards that choice with a recovery watchdog. At power-up, three hardware select straps are sampled while a low-active power-good strobe is asserted. When that strobe is released, the straps are frozen. Software can then override the strap code with a register field, or switch the synthesizer into direct M/N programming. Register contents arrive as plain ports with one write strobe per register. A single-cycle timebase tick stands in for one 250 ms unit.

The watchdog must be armed in a fixed order: first the enable bit is set, then a 7-bit count is written. Writing a nonzero count starts a down-count of one per tick. If the count reaches zero, the watchdog does the following:
- drives an active-low reset output for a programmable number of ticks;
- drops M/N programming;
- reloads the software code field, either from the latched straps or from a separate safe code, as a policy bit selects.

The watchdog is a four-state machine:
- `WD_IDLE`: the watchdog is off.
- `WD_ARMED`: the watchdog is enabled and waiting for a count.
- `WD_COUNT`: the down-count is running.
- `WD_PULSE`: the reset output is low.

The state transitions are:
- *arm* (`WD_IDLE`→`WD_ARMED`): enable written as 1.
- *start* (`WD_ARMED`→`WD_COUNT`): a nonzero count is written.
- *park* (`WD_COUNT`→`WD_ARMED`): a zero count is written.
- *disarm* (`WD_ARMED` or `WD_COUNT`→`WD_IDLE`): enable written as 0.
- *expire* (`WD_COUNT`→`WD_PULSE`): a tick arrives with the count at 1.
- *release* (`WD_PULSE`→`WD_IDLE`): the last pulse tick arrives.

Top module: `fsel_wdog_ctrl`

## Requirements
- R1: While `pwrgd_n` is low at a clock edge, `strap_o` takes `strap_i`. While `pwrgd_n` is high, `strap_o` holds its value.
- R2: `freq_code_o` equals `sw_code_o` when the software-select bit is 1. When that bit is 0, `freq_code_o` equals `{2'b00, strap_o}`, with the strap in bits 2:0. A write on `sel_wr_i` loads the select bit, the code and the policy bit together.
- R3: A count write starts the down-count only if the watchdog is armed (enable written 1 earlier). In `WD_IDLE`, a count write only loads `wd_count_o`.
- R4: In `WD_COUNT`, `wd_count_o` drops by one per tick and always shows the live value. Its reset value is 8.
- R5: `wd_en_o` reads 1 in `WD_ARMED` and `WD_COUNT`. It reads 0 in `WD_IDLE` and during the reset pulse that follows expiry.
- R6: `wd_flag_o` rises in the cycle the count reaches zero. It holds until a nonzero count write restarts the armed watchdog.
- R7: On expiry, `rst_pulse_n_o` goes low in the same cycle as `wd_flag_o` rises. It stays low until `PULSE_TICKS` ticks (default 1) have arrived.
- R8: Expiry clears `mn_en_o`, overriding a write on `mn_wr_i` in the same cycle.
- R9: On expiry, `sw_code_o` is reloaded. With policy bit 0 it takes `{2'b00, strap_o}`. With policy bit 1 it takes the safe code written through `wd_wr_i`.
- R10: Writing a count of zero while armed parks the watchdog in `WD_ARMED`: no expiry follows and `wd_count_o` stays 0.
- R11: After power-on reset, the outputs take these values:
  - `wd_count_o` is 8;
  - `sw_code_o` is 00010;
  - the safe code is 00010;
  - `wd_en_o`, `wd_flag_o`, `mn_en_o`, `strap_o` and the policy and select bits are 0;
  - `rst_pulse_n_o` is 1.
- R12: When armed or counting, a disable write takes precedence over a count write in the same cycle, which in turn takes precedence over a tick. A count write still loads `wd_count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pwrgd_n | input | 1 | Active-low power-good strobe; straps are captured while it is low |
| strap_i | input | 3 | Hardware select straps |
| tick_i | input | 1 | Single-cycle timebase tick, one per 250 ms unit |
| sel_wr_i | input | 1 | Write strobe for the select register |
| sel_en_i | input | 1 | Software-select bit |
| sel_code_i | input | 5 | Software frequency code |
| safe_pol_i | input | 1 | Reload policy: 0 reloads from the straps, 1 from the safe code |
| wd_wr_i | input | 1 | Write strobe for the watchdog control register |
| wd_en_i | input | 1 | Watchdog enable |
| safe_code_i | input | 5 | Safe frequency code |
| mn_wr_i | input | 1 | Write strobe for the M/N mode bit |
| mn_en_i | input | 1 | M/N programming enable |
| cnt_wr_i | input | 1 | Write strobe for the count register |
| cnt_i | input | 7 | Timeout count in ticks |
| freq_code_o | output | 5 | Active frequency-table code |
| mn_en_o | output | 1 | M/N programming mode flag |
| rst_pulse_n_o | output | 1 | Active-low reset pulse |
| strap_o | output | 3 | Latched strap status |
| sw_code_o | output | 5 | Software frequency code readback |
| wd_en_o | output | 1 | Watchdog enable readback |
| wd_flag_o | output | 1 | Timeout flag |
| wd_count_o | output | 7 | Live down-count value |

## Verification
All registers are loaded at a single clock edge. Every write, tick or strobe sampled at edge N therefore shows at the outputs right after edge N. This includes `freq_code_o`, which is a combinational mux over registered fields, and the expiry effects (flag, pulse, M/N clear and code reload), which all land together at the edge where the last tick is seen. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares every output against its reference model on the following falling edge. Pulse length is checked by counting ticks, not cycles.

// File: rtl/fsel_wdog_pkg.sv
package fsel_wdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_COUNT = 2'd2,
        WD_PULSE = 2'd3
    } wd_state_t;

    localparam logic [4:0] SW_CODE_RST   = 5'b00010;
    localparam logic [4:0] SAFE_CODE_RST = 5'b00010;

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
    parameter int STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwrgd_n,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [STRAP_W-1:0] strap_q
);

    // Transparent capture while the power-good strobe is asserted (low).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= '0;
        end else if (!pwrgd_n) begin
            strap_q <= strap_i;
        end
    end

endmodule

// File: rtl/fsel_wdog_fsm.sv
module fsel_wdog_fsm
    import fsel_wdog_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int CNT_RST     = 8,
    parameter int PULSE_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_wr_i,
    input  logic             en_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o,
    output logic             en_rb_o,
    output logic             flag_o,
    output logic             pulse_n_o
);

    localparam int               PULSE_W    = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_INIT   = CNT_W'(CNT_RST);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
    localparam logic [PULSE_W-1:0] PULSE_LD  = PULSE_W'(PULSE_TICKS);
    localparam logic [PULSE_W-1:0] PULSE_ONE = PULSE_W'(1);

    wd_state_t          state_q, state_nx;
    logic [CNT_W-1:0]   count_q;
    logic [PULSE_W-1:0] pulse_q;
    logic               flag_q;

    logic disable_req;
    logic start_req;
    logic restart;
    logic expire;
    logic count_dec;

    assign disable_req = en_wr_i && !en_i;
    assign start_req   = cnt_wr_i && (cnt_i != '0);

    // Next-state and event decode
    always_comb begin
        state_nx  = state_q;
        restart   = 1'b0;
        expire    = 1'b0;
        count_dec = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (en_wr_i && en_i) begin
                    state_nx = WD_ARMED;                 // arm
                end
            end
            WD_ARMED: begin
                if (disable_req) begin
                    state_nx = WD_IDLE;                  // disarm
                end else if (start_req) begin
                    state_nx = WD_COUNT;                 // start
                    restart  = 1'b1;
                end
            end
            WD_COUNT: begin
                if (disable_req) begin
                    state_nx = WD_IDLE;                  // disarm
                end else if (cnt_wr_i) begin
                    if (start_req) begin
                        restart  = 1'b1;                 // reload while running
                    end else begin
                        state_nx = WD_ARMED;             // park on zero write
                    end
                end else if (tick_i && count_q != '0) begin
                    count_dec = 1'b1;
                    if (count_q == CNT_ONE) begin
                        state_nx = WD_PULSE;             // expire
                        expire   = 1'b1;
                    end
                end
            end
            WD_PULSE: begin
                if (tick_i && pulse_q == PULSE_ONE) begin
                    state_nx = WD_IDLE;                  // release
                end
            end
            default: state_nx = WD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Count, pulse length and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_INIT;
            pulse_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (cnt_wr_i) begin
                count_q <= cnt_i;
            end else if (count_dec) begin
                count_q <= count_q - CNT_ONE;
            end

            if (expire) begin
                pulse_q <= PULSE_LD;
            end else if (state_q == WD_PULSE && tick_i && pulse_q != '0) begin
                pulse_q <= pulse_q - PULSE_ONE;
            end

            if (expire) begin
                flag_q <= 1'b1;
            end else if (restart) begin
                flag_q <= 1'b0;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        en_rb_o   = (state_q == WD_ARMED) || (state_q == WD_COUNT);
        pulse_n_o = (state_q != WD_PULSE);
        expire_o  = expire;
        count_o   = count_q;
        flag_o    = flag_q;
    end

endmodule

// File: rtl/fsel_cfg_regs.sv
module fsel_cfg_regs
    import fsel_wdog_pkg::*;
#(
    parameter int CODE_W  = 5,
    parameter int STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr_i,
    input  logic               sel_en_i,
    input  logic [CODE_W-1:0]  sel_code_i,
    input  logic               safe_pol_i,
    input  logic               wd_wr_i,
    input  logic [CODE_W-1:0]  safe_code_i,
    input  logic               mn_wr_i,
    input  logic               mn_en_i,
    input  logic               expire_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [CODE_W-1:0]  freq_code_o,
    output logic [CODE_W-1:0]  sw_code_o,
    output logic               mn_en_o
);

    localparam int PAD_W = CODE_W - STRAP_W;

    logic              sel_en_q;
    logic              pol_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] safe_q;
    logic              mn_q;
    logic [CODE_W-1:0] strap_code;
    logic [CODE_W-1:0] reload_code;

    generate
        if (PAD_W > 0) begin : g_pad
            assign strap_code = {{PAD_W{1'b0}}, strap_i};
        end else begin : g_nopad
            assign strap_code = strap_i[CODE_W-1:0];
        end
    endgenerate

    assign reload_code = pol_q ? safe_q : strap_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_en_q <= 1'b0;
            pol_q    <= 1'b0;
            code_q   <= SW_CODE_RST;
            safe_q   <= SAFE_CODE_RST;
            mn_q     <= 1'b0;
        end else begin
            if (sel_wr_i) begin
                sel_en_q <= sel_en_i;
                pol_q    <= safe_pol_i;
            end
            if (wd_wr_i) begin
                safe_q <= safe_code_i;
            end
            // Expiry overrides same-cycle software writes to code and mode
            if (expire_i) begin
                code_q <= reload_code;
                mn_q   <= 1'b0;
            end else begin
                if (sel_wr_i) begin
                    code_q <= sel_code_i;
                end
                if (mn_wr_i) begin
                    mn_q <= mn_en_i;
                end
            end
        end
    end

    assign freq_code_o = sel_en_q ? code_q : strap_code;
    assign sw_code_o   = code_q;
    assign mn_en_o     = mn_q;

endmodule

// File: rtl/fsel_wdog_ctrl.sv
module fsel_wdog_ctrl #(
    parameter int CODE_W      = 5,
    parameter int STRAP_W     = 3,
    parameter int CNT_W       = 7,
    parameter int CNT_RST     = 8,
    parameter int PULSE_TICKS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwrgd_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               tick_i,
    input  logic               sel_wr_i,
    input  logic               sel_en_i,
    input  logic [CODE_W-1:0]  sel_code_i,
    input  logic               safe_pol_i,
    input  logic               wd_wr_i,
    input  logic               wd_en_i,
    input  logic [CODE_W-1:0]  safe_code_i,
    input  logic               mn_wr_i,
    input  logic               mn_en_i,
    input  logic               cnt_wr_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [CODE_W-1:0]  freq_code_o,
    output logic               mn_en_o,
    output logic               rst_pulse_n_o,
    output logic [STRAP_W-1:0] strap_o,
    output logic [CODE_W-1:0]  sw_code_o,
    output logic               wd_en_o,
    output logic               wd_flag_o,
    output logic [CNT_W-1:0]   wd_count_o
);

    logic               expire;
    logic [STRAP_W-1:0] strap_q;

    fsel_strap_latch #(
        .STRAP_W (STRAP_W)
    ) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrgd_n (pwrgd_n),
        .strap_i (strap_i),
        .strap_q (strap_q)
    );

    fsel_wdog_fsm #(
        .CNT_W       (CNT_W),
        .CNT_RST     (CNT_RST),
        .PULSE_TICKS (PULSE_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .en_wr_i   (wd_wr_i),
        .en_i      (wd_en_i),
        .cnt_wr_i  (cnt_wr_i),
        .cnt_i     (cnt_i),
        .expire_o  (expire),
        .count_o   (wd_count_o),
        .en_rb_o   (wd_en_o),
        .flag_o    (wd_flag_o),
        .pulse_n_o (rst_pulse_n_o)
    );

    fsel_cfg_regs #(
        .CODE_W  (CODE_W),
        .STRAP_W (STRAP_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr_i    (sel_wr_i),
        .sel_en_i    (sel_en_i),
        .sel_code_i  (sel_code_i),
        .safe_pol_i  (safe_pol_i),
        .wd_wr_i     (wd_wr_i),
        .safe_code_i (safe_code_i),
        .mn_wr_i     (mn_wr_i),
        .mn_en_i     (mn_en_i),
        .expire_i    (expire),
        .strap_i     (strap_q),
        .freq_code_o (freq_code_o),
        .sw_code_o   (sw_code_o),
        .mn_en_o     (mn_en_o)
    );

    assign strap_o = strap_q;

endmodule

// File: rtl/fsel_wdog_chk.sv
module fsel_wdog_chk #(
    parameter int STRAP_W = 3,
    parameter int CNT_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwrgd_n,
    input logic [STRAP_W-1:0] strap_o,
    input logic               mn_en_o,
    input logic               rst_pulse_n_o,
    input logic               wd_en_o,
    input logic               wd_flag_o,
    input logic [CNT_W-1:0]   wd_count_o
);

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwrgd_n) |-> $stable(strap_o)); // R1

    AST_EN_LOW_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pulse_n_o |-> !wd_en_o); // R5

    AST_FLAG_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag_o && !wd_en_o) |=> wd_flag_o); // R6

    AST_PULSE_WITH_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse_n_o) |-> (wd_flag_o && wd_count_o == '0)); // R7

    AST_MN_OFF_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag_o) |-> !mn_en_o); // R8

endmodule

bind fsel_wdog_ctrl fsel_wdog_chk #(
    .STRAP_W (STRAP_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwrgd_n       (pwrgd_n),
    .strap_o       (strap_o),
    .mn_en_o       (mn_en_o),
    .rst_pulse_n_o (rst_pulse_n_o),
    .wd_en_o       (wd_en_o),
    .wd_flag_o     (wd_flag_o),
    .wd_count_o    (wd_count_o)
);

// File: tb/test_fsel_wdog_ctrl.sv
`timescale 1ns/1ps
module test_fsel_wdog_ctrl;

    localparam int PT = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrgd_n = 1'b1;
    logic [2:0] strap_i = '0;
    logic       tick_i = 1'b0;
    logic       sel_wr_i = 1'b0, sel_en_i = 1'b0, safe_pol_i = 1'b0;
    logic [4:0] sel_code_i = '0, safe_code_i = '0;
    logic       wd_wr_i = 1'b0, wd_en_i = 1'b0;
    logic       mn_wr_i = 1'b0, mn_en_i = 1'b0;
    logic       cnt_wr_i = 1'b0;
    logic [6:0] cnt_i = '0;

    logic [4:0] freq_code_o, sw_code_o;
    logic       mn_en_o, rst_pulse_n_o, wd_en_o, wd_flag_o;
    logic [2:0] strap_o;
    logic [6:0] wd_count_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 armed, 2 counting, 3 pulse
    int m_st, m_cnt, m_pulse, m_strap, m_code, m_safe;
    bit m_flag, m_sel, m_pol, m_mn;

    always #2.5 clk = ~clk;

    fsel_wdog_ctrl i_fsel_wdog_ctrl (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_i(strap_i),
        .tick_i(tick_i), .sel_wr_i(sel_wr_i), .sel_en_i(sel_en_i),
        .sel_code_i(sel_code_i), .safe_pol_i(safe_pol_i), .wd_wr_i(wd_wr_i),
        .wd_en_i(wd_en_i), .safe_code_i(safe_code_i), .mn_wr_i(mn_wr_i),
        .mn_en_i(mn_en_i), .cnt_wr_i(cnt_wr_i), .cnt_i(cnt_i),
        .freq_code_o(freq_code_o), .mn_en_o(mn_en_o),
        .rst_pulse_n_o(rst_pulse_n_o), .strap_o(strap_o),
        .sw_code_o(sw_code_o), .wd_en_o(wd_en_o), .wd_flag_o(wd_flag_o),
        .wd_count_o(wd_count_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_cnt = 8; m_pulse = 0; m_strap = 0; m_code = 2; m_safe = 2;
        m_flag = 0; m_sel = 0; m_pol = 0; m_mn = 0;
    endtask

    // Reference behaviour per R1..R12, applied for one rising edge
    task automatic model_step();
        bit dis, start, restart, expire;
        int ns, ncnt, npulse, nstrap, ncode;
        bit nmn;
        dis = wd_wr_i && !wd_en_i;
        start = cnt_wr_i && (cnt_i != 0);
        restart = 0; expire = 0; ns = m_st;
        case (m_st)
            0: if (wd_wr_i && wd_en_i) ns = 1;
            1: if (dis) ns = 0; else if (start) begin ns = 2; restart = 1; end
            2: if (dis) ns = 0;
               else if (cnt_wr_i) begin if (start) restart = 1; else ns = 1; end
               else if (tick_i && m_cnt == 1) begin ns = 3; expire = 1; end
            default: if (tick_i && m_pulse == 1) ns = 0;
        endcase
        ncnt = m_cnt;
        if (cnt_wr_i) ncnt = cnt_i;
        else if (m_st == 2 && !dis && tick_i && m_cnt != 0) ncnt = m_cnt - 1;
        npulse = m_pulse;
        if (expire) npulse = PT;
        else if (m_st == 3 && tick_i && m_pulse != 0) npulse = m_pulse - 1;
        nstrap = pwrgd_n ? m_strap : int'(strap_i);
        ncode = m_code; nmn = m_mn;
        if (sel_wr_i) ncode = sel_code_i;
        if (mn_wr_i) nmn = mn_en_i;
        if (expire) begin
            ncode = m_pol ? m_safe : m_strap;
            nmn = 0;
        end
        if (sel_wr_i) begin m_sel = sel_en_i; m_pol = safe_pol_i; end
        if (wd_wr_i) m_safe = safe_code_i;
        if (expire) m_flag = 1; else if (restart) m_flag = 0;
        m_st = ns; m_cnt = ncnt; m_pulse = npulse; m_strap = nstrap;
        m_code = ncode; m_mn = nmn;
    endtask

    task automatic compare();
        chk("R1 strap_o", int'(strap_o), m_strap);
        chk("R2 freq_code_o", int'(freq_code_o), m_sel ? m_code : m_strap);
        chk("R9 sw_code_o", int'(sw_code_o), m_code);
        chk("R4 wd_count_o", int'(wd_count_o), m_cnt);
        chk("R5 wd_en_o", int'(wd_en_o), (m_st == 1 || m_st == 2) ? 1 : 0);
        chk("R6 wd_flag_o", int'(wd_flag_o), int'(m_flag));
        chk("R7 rst_pulse_n_o", int'(rst_pulse_n_o), (m_st == 3) ? 0 : 1);
        chk("R8 mn_en_o", int'(mn_en_o), int'(m_mn));
    endtask

    task automatic quiet();
        tick_i = 0; sel_wr_i = 0; wd_wr_i = 0; mn_wr_i = 0; cnt_wr_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        quiet();
    endtask

    task automatic wr_cnt(input int v);
        cnt_wr_i = 1; cnt_i = 7'(v); step();
    endtask

    task automatic wr_wd(input bit en, input int safe);
        wd_wr_i = 1; wd_en_i = en; safe_code_i = 5'(safe); step();
    endtask

    task automatic wr_sel(input bit en, input int code, input bit pol);
        sel_wr_i = 1; sel_en_i = en; sel_code_i = 5'(code); safe_pol_i = pol; step();
    endtask

    task automatic tick_step();
        tick_i = 1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare();
        // R11 reset state
        chk("R11 count reset", int'(wd_count_o), 8);
        chk("R11 sw code reset", int'(sw_code_o), 2);
        chk("R11 pulse idle", int'(rst_pulse_n_o), 1);
        chk("R11 flag reset", int'(wd_flag_o), 0);

        // R1 capture while strobe low, freeze after
        pwrgd_n = 0; strap_i = 3'd5; step();
        chk("R1 captured", int'(strap_o), 5);
        chk("R2 strap code", int'(freq_code_o), 5);
        pwrgd_n = 1; strap_i = 3'd2; step();
        chk("R1 frozen", int'(strap_o), 5);

        // R2 software select
        wr_sel(1, 5'h13, 0);
        chk("R2 software code", int'(freq_code_o), 5'h13);

        // R3 count write when not armed does not start
        wr_cnt(3); tick_step(); tick_step();
        chk("R3 idle count held", int'(wd_count_o), 3);
        chk("R3 idle not enabled", int'(wd_en_o), 0);

        // R10 zero write while armed parks
        wr_wd(1, 2);
        wr_cnt(0); tick_step(); tick_step(); tick_step();
        chk("R10 no expiry flag", int'(wd_flag_o), 0);
        chk("R10 armed", int'(wd_en_o), 1);
        chk("R10 count zero", int'(wd_count_o), 0);

        // R4..R9 expiry with strap reload
        mn_wr_i = 1; mn_en_i = 1; step();
        wr_cnt(2);
        chk("R3 started", int'(wd_en_o), 1);
        tick_step();
        chk("R4 live count", int'(wd_count_o), 1);
        tick_step();
        chk("R6 flag set", int'(wd_flag_o), 1);
        chk("R7 pulse low", int'(rst_pulse_n_o), 0);
        chk("R8 mn cleared", int'(mn_en_o), 0);
        chk("R9 strap reload", int'(sw_code_o), 5);
        chk("R5 enable reads 0", int'(wd_en_o), 0);
        step();
        chk("R7 pulse still low", int'(rst_pulse_n_o), 0);
        tick_step();
        chk("R7 pulse ended", int'(rst_pulse_n_o), 1);

        // R9 safe code reload
        wr_sel(1, 5'h13, 1);
        wr_wd(1, 5'h1C);
        wr_cnt(1);
        tick_step();
        chk("R9 safe reload", int'(sw_code_o), 5'h1C);
        chk("R9 safe code drives", int'(freq_code_o), 5'h1C);
        tick_step();

        // R6 restart clears flag; R12 priority
        wr_wd(1, 5'h1C);
        wr_cnt(5);
        chk("R6 flag cleared", int'(wd_flag_o), 0);
        wd_wr_i = 1; wd_en_i = 0; cnt_wr_i = 1; cnt_i = 7'd4; tick_i = 1; step();
        chk("R12 disable wins", int'(wd_en_o), 0);
        chk("R12 count loaded", int'(wd_count_o), 4);

        // Constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            pwrgd_n = ($urandom % 20) != 0;
            strap_i = 3'($urandom);
            tick_i = ($urandom % 4) == 0;
            if ($urandom % 24 == 0) begin
                sel_wr_i = 1; sel_en_i = 1'($urandom);
                sel_code_i = 5'($urandom); safe_pol_i = 1'($urandom);
            end
            if ($urandom % 10 == 0) begin
                wd_wr_i = 1; wd_en_i = ($urandom % 4) != 0;
                safe_code_i = 5'($urandom);
            end
            if ($urandom % 12 == 0) begin
                cnt_wr_i = 1; cnt_i = 7'($urandom % 6);
            end
            if ($urandom % 16 == 0) begin
                mn_wr_i = 1; mn_en_i = 1'($urandom);
            end
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule